// File: doc/BRIEF.md
# Smart-Card Multi-Mode Timeout Counter

This block times the I/O line of a smart-card interface. It has three 8-bit reload registers and a mode byte, and it counts down on an elementary-time-unit (ETU) tick. The mode byte decides three things. The first is how the counting is grouped: a "short" 8-bit counter beside a "long" 16-bit counter, or a single 24-bit long counter. The second is when each group starts: at the mode write, at the first start bit, or at every start bit. The third is whether counting is cut off a fixed number of ETUs after the first start bit.

A host writes the reload registers and then the mode byte through a simple write port. Start-bit strobes come from the card UART, for received or transmitted characters, and ETU ticks come from the baud generator. Terminal counts set two sticky flags, and their OR drives an interrupt. The host clears both flags with a one-cycle strobe.

Top module: `card_timeout_unit`

## Requirements
- R1: Write address 0 holds the mode byte. Addresses 1, 2 and 3 hold reload bytes A, B and C. After reset every register is zero, both counters are stopped, and flag_short, flag_long and irq are 0.
- R2: A running counter loaded with N decrements once per etu_tick. Its terminal count comes on the N-th tick after loading, and a loaded zero behaves as one. The flag shows the event in the first cycle after the clock edge that sampled the terminal tick.
- R3: In modes 0x65, 0x75, 0xE5 and 0xF5, the short counter waits for the first start_bit after the mode write and then loads reload A. It auto-reloads, so flag_short is set every A ticks.
- R4: In modes 0x65 and 0xE5, the long counter loads {C,B} (16 bits, C the high byte) at the mode write. It sets flag_long at its terminal count and then stays stopped at zero.
- R5: Mode 0x68 joins all three bytes into a 24-bit long counter loaded with {C,B,A} at the mode write. Its terminal count sets flag_long. The short counter is idle in this mode.
- R6: In modes 0x71, 0x75, 0xF1 and 0xF5, the long counter loads {C,B} on every start_bit. In mode 0x7C it loads {C,B,A} on every start_bit. A write to a reload register during a count leaves the running count unchanged, and the new value applies at the next start_bit.
- R7: In modes 0x71, 0x7C and 0xF1 the short counter never runs, so flag_short stays 0 even when start bits arrive.
- R8: Mode 0x00 stops both counters, and any mode value not listed here does the same. Mode 0x05 stops only the long counter and leaves the short counter running as before.
- R9: Modes 0x85, 0xE5, 0xF1 and 0xF5 add a cut-off to modes 0x05, 0x65, 0x71 and 0x75 respectively. The cut-off falls on the 12th etu_tick after the first start_bit that follows the mode write. 0x85 and 0xF5 stop both counters, 0xE5 stops the short counter and 0xF1 stops the long counter. The 12th tick is still counted, and later start bits do not restart a counter that has been cut off.
- R10: flag_short and flag_long stay set until clr_flags is pulsed. A terminal count in the same cycle as clr_flags leaves its flag set. irq is the OR of the two flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 mode, 1..3 reload A..C) |
| wr_data | input | 8 | Register write data |
| etu_tick | input | 1 | One-cycle pulse per ETU |
| start_bit | input | 1 | One-cycle pulse on a detected start bit |
| clr_flags | input | 1 | Clears both status flags |
| flag_short | output | 1 | Sticky terminal-count flag of the short counter |
| flag_long | output | 1 | Sticky terminal-count flag of the long counter |
| irq | output | 1 | Interrupt, OR of the two flags |

## Verification
The bench sweeps the reload values of both counters and checks that each terminal lands exactly on the N-th tick. An off-by-one load or decrement would move the flag a tick early or late, and a zero load that is not treated as one would never fire. It checks the byte order of the joined 24-bit count by using values in which each byte contributes, so swapped or dropped bytes give a visibly wrong length. It restarts the every-start-bit counter in mid-count and rewrites its reload register while it runs; a design that reloads too eagerly, or not at all, sets the flag at the wrong tick. The cut-off modes place a terminal count on the 12th tick and send start bits after the cut-off, which catches a cut-off that is one tick off, a counter that is stopped in the wrong group, and a counter that is re-armed after it has been cut off.

// File: rtl/card_tmo_pkg.sv
package card_tmo_pkg;

    localparam int DATA_W  = 8;              // width of one segment / register
    localparam int NSEG    = 3;              // segments available to the long counter
    localparam int ADDR_W  = 2;
    localparam int LONG_W  = DATA_W * NSEG;
    localparam int SHORT_W = DATA_W;

    typedef enum logic [1:0] {S_OFF, S_KEEP, S_FIRST} short_act_e;
    typedef enum logic [1:0] {L_OFF, L_WRITE, L_EVERY} long_act_e;
    typedef enum logic [1:0] {CP_IDLE, CP_WAIT, CP_COUNT} cut_phase_e;

    typedef struct packed {
        short_act_e s_act;
        long_act_e  l_act;
        logic       joined;   // long counter spans all segments
        logic       cut_s;    // cut-off stops short counter
        logic       cut_l;    // cut-off stops long counter
    } mode_cfg_t;

    localparam mode_cfg_t CFG_OFF = '{s_act: S_OFF, l_act: L_OFF,
                                      joined: 1'b0, cut_s: 1'b0, cut_l: 1'b0};

    function automatic mode_cfg_t tmo_decode(input logic [DATA_W-1:0] code);
        mode_cfg_t c;
        c = CFG_OFF;
        case (code)
            8'h05: c.s_act = S_KEEP;
            8'h65: begin c.s_act = S_FIRST; c.l_act = L_WRITE; end
            8'h68: begin c.l_act = L_WRITE; c.joined = 1'b1; end
            8'h71: c.l_act = L_EVERY;
            8'h75: begin c.s_act = S_FIRST; c.l_act = L_EVERY; end
            8'h7C: begin c.l_act = L_EVERY; c.joined = 1'b1; end
            8'h85: begin c.s_act = S_KEEP; c.cut_s = 1'b1; c.cut_l = 1'b1; end
            8'hE5: begin c.s_act = S_FIRST; c.l_act = L_WRITE; c.cut_s = 1'b1; end
            8'hF1: begin c.l_act = L_EVERY; c.cut_l = 1'b1; end
            8'hF5: begin c.s_act = S_FIRST; c.l_act = L_EVERY;
                         c.cut_s = 1'b1; c.cut_l = 1'b1; end
            default: c = CFG_OFF;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tmo_down_counter.sv
module tmo_down_counter #(
    parameter int W    = 8,
    parameter bit AUTO = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         stop,
    input  logic         tick,
    input  logic [W-1:0] load_val,
    output logic         tc,
    output logic         running
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;
    logic         run;

    assign tc      = run && tick && !load && (cnt <= ONE);
    assign running = run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else begin
            if (load) begin
                cnt <= load_val;
                run <= 1'b1;
            end else if (run && tick) begin
                if (cnt <= ONE) begin
                    if (AUTO) begin
                        cnt <= load_val;
                    end else begin
                        cnt <= '0;
                        run <= 1'b0;
                    end
                end else begin
                    cnt <= cnt - ONE;
                end
            end
            if (stop) run <= 1'b0;
        end
    end

    // R2: one step per tick while above the terminal value
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        run && tick && !load && (cnt > ONE) |=> cnt == $past(cnt) - ONE);
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        run && !tick && !load && !stop |=> run && $stable(cnt));
    // R4: a single-shot counter rests at zero after terminal count
    p_single_rest_r4: assert property (@(posedge clk) disable iff (rst)
        !AUTO && tc |=> !run && (cnt == '0));
    // R3: an auto-reload counter restarts from the reload value
    p_auto_reload_r3: assert property (@(posedge clk) disable iff (rst)
        AUTO && tc && !stop |=> run && (cnt == $past(load_val)));

endmodule

// File: rtl/tmo_cutoff.sv
module tmo_cutoff
    import card_tmo_pkg::*;
#(
    parameter int CUT_ETUS = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_wr,
    input  logic arm,
    input  logic start,
    input  logic tick,
    output logic cut
);
    localparam int CW = $clog2(CUT_ETUS + 1);
    localparam logic [CW-1:0] LAST = CW'(CUT_ETUS - 1);

    cut_phase_e    phase;
    logic [CW-1:0] n;

    assign cut = (phase == CP_COUNT) && tick && (n == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= CP_IDLE;
            n     <= '0;
        end else if (mode_wr) begin
            phase <= arm ? CP_WAIT : CP_IDLE;
            n     <= '0;
        end else begin
            case (phase)
                CP_WAIT: if (start) begin
                    phase <= CP_COUNT;
                    n     <= '0;
                end
                CP_COUNT: if (tick) begin
                    if (n == LAST) phase <= CP_IDLE;
                    else           n     <= n + CW'(1);
                end
                default: ;
            endcase
        end
    end

    // R9: the cut-off fires once per armed window
    p_cut_once_r9: assert property (@(posedge clk) disable iff (rst)
        cut |=> !cut && (phase == CP_IDLE));
    p_cut_bound_r9: assert property (@(posedge clk) disable iff (rst)
        phase == CP_COUNT |-> n <= LAST);

endmodule

// File: rtl/card_timeout_unit.sv
module card_timeout_unit
    import card_tmo_pkg::*;
#(
    parameter int CUT_ETUS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              etu_tick,
    input  logic              start_bit,
    input  logic              clr_flags,
    output logic              flag_short,
    output logic              flag_long,
    output logic              irq
);
    logic [DATA_W-1:0] rl [NSEG];
    mode_cfg_t         mode_q, dec;
    logic              mwr, stb, first, seen_start, live_s, live_l, cut;
    logic              s_load, s_stop, s_tc, s_run;
    logic              l_load, l_stop, l_tc, l_run, sel_joined;
    logic [LONG_W-1:0] joined_val, split_val, l_val;

    assign mwr   = wr_en && (wr_addr == '0);
    assign dec   = tmo_decode(wr_data);
    assign stb   = start_bit && !mwr;
    assign first = stb && !seen_start;

    // reload registers, one per segment
    for (genvar i = 0; i < NSEG; i++) begin : g_rl
        always_ff @(posedge clk) begin
            if (rst)                                         rl[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i + 1))     rl[i] <= wr_data;
        end
    end

    always_comb begin
        joined_val = '0;
        split_val  = '0;
        for (int i = 0; i < NSEG; i++) begin
            joined_val[i*DATA_W +: DATA_W] = rl[i];
            if (i > 0) split_val[(i-1)*DATA_W +: DATA_W] = rl[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= CFG_OFF;
            seen_start <= 1'b0;
            live_s     <= 1'b0;
            live_l     <= 1'b0;
        end else if (mwr) begin
            mode_q     <= dec;
            seen_start <= 1'b0;
            live_s     <= 1'b1;
            live_l     <= 1'b1;
        end else begin
            if (stb)                 seen_start <= 1'b1;
            if (cut && mode_q.cut_s) live_s     <= 1'b0;
            if (cut && mode_q.cut_l) live_l     <= 1'b0;
        end
    end

    assign s_load = first && (mode_q.s_act == S_FIRST) && live_s;
    assign s_stop = (mwr && dec.s_act != S_KEEP) || (cut && mode_q.cut_s);

    assign sel_joined = mwr ? dec.joined : mode_q.joined;
    assign l_val      = sel_joined ? joined_val : split_val;
    assign l_load     = (mwr && dec.l_act == L_WRITE)
                     || (stb && mode_q.l_act == L_EVERY && live_l);
    assign l_stop     = (mwr && dec.l_act != L_WRITE) || (cut && mode_q.cut_l);

    tmo_down_counter #(.W(SHORT_W), .AUTO(1'b1)) u_short (
        .clk(clk), .rst(rst), .load(s_load), .stop(s_stop), .tick(etu_tick),
        .load_val(rl[0]), .tc(s_tc), .running(s_run));

    tmo_down_counter #(.W(LONG_W), .AUTO(1'b0)) u_long (
        .clk(clk), .rst(rst), .load(l_load), .stop(l_stop), .tick(etu_tick),
        .load_val(l_val), .tc(l_tc), .running(l_run));

    tmo_cutoff #(.CUT_ETUS(CUT_ETUS)) u_cut (
        .clk(clk), .rst(rst), .mode_wr(mwr), .arm(dec.cut_s || dec.cut_l),
        .start(stb), .tick(etu_tick), .cut(cut));

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_short <= 1'b0;
            flag_long  <= 1'b0;
        end else begin
            if (s_tc)           flag_short <= 1'b1;
            else if (clr_flags) flag_short <= 1'b0;
            if (l_tc)           flag_long  <= 1'b1;
            else if (clr_flags) flag_long  <= 1'b0;
        end
    end

    assign irq = flag_short || flag_long;

    // R10: flags are sticky and a clear without a new event empties them
    p_sticky_short_r10: assert property (@(posedge clk) disable iff (rst)
        flag_short && !clr_flags |=> flag_short);
    p_clear_long_r10: assert property (@(posedge clk) disable iff (rst)
        clr_flags && !l_tc |=> !flag_long);
    // R8: a stop-all mode write leaves nothing running
    p_off_stops_r8: assert property (@(posedge clk) disable iff (rst)
        mwr && dec.s_act == S_OFF && dec.l_act == L_OFF |=> !s_run && !l_run);
    // R9: after a long cut-off the long counter is idle
    p_cut_long_r9: assert property (@(posedge clk) disable iff (rst)
        cut && mode_q.cut_l |=> !l_run);
    // R7: the short counter never starts in modes that leave it idle
    p_short_idle_r7: assert property (@(posedge clk) disable iff (rst)
        mode_q.s_act == S_OFF && !s_run |=> !s_run);

endmodule

// File: tb/card_timeout_unit_tb.sv
module card_timeout_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, etu_tick = 1'b0, start_bit = 1'b0, clr_flags = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       flag_short, flag_long, irq;
    int         checks = 0, errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    card_timeout_unit u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .etu_tick(etu_tick), .start_bit(start_bit), .clr_flags(clr_flags),
        .flag_short(flag_short), .flag_long(flag_long), .irq(irq));

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d; step(); wr_en = 1'b0;
    endtask

    task automatic set_rl(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        wr(2'd1, a); wr(2'd2, b); wr(2'd3, c);
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin etu_tick = 1'b1; step(); etu_tick = 1'b0; end
    endtask

    task automatic strt();
        start_bit = 1'b1; step(); start_bit = 1'b0;
    endtask

    task automatic clr();
        clr_flags = 1'b1; step(); clr_flags = 1'b0;
    endtask

    task automatic expect_f(input logic s, input logic l, input string req);
        logic [2:0] act, exp;
        act = {flag_short, flag_long, irq};
        exp = {s, l, s | l};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {short,long,irq} actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); step(); rst = 1'b0; step();
        expect_f(0, 0, "R1 reset");

        // R4 / R2: long single-shot sweep, zero acts as one
        for (int n = 0; n <= 5; n++) begin
            set_rl(8'd0, 8'(n), 8'd0);
            wr(2'd0, 8'h65); clr();
            tk((n == 0) ? 0 : n - 1);
            expect_f(0, 0, "R2 before terminal");
            tk(1);
            expect_f(0, 1, "R4 terminal at N");
            clr(); tk(3);
            expect_f(0, 0, "R4 stays stopped");
        end

        // R3: short auto-reload sweep, waits for start bit
        for (int n = 1; n <= 4; n++) begin
            set_rl(8'(n), 8'hFF, 8'd1);
            wr(2'd0, 8'h65); clr();
            tk(2);
            expect_f(0, 0, "R3 waits for start");
            strt();
            for (int p = 0; p < 3; p++) begin
                tk(n - 1);
                expect_f(0, 0, "R3 mid period");
                tk(1);
                expect_f(1, 0, "R3 period end");
                clr();
            end
        end

        // R5: joined 24-bit count {C,B,A}
        set_rl(8'd2, 8'd1, 8'd0);
        wr(2'd0, 8'h68); clr();
        strt(); tk(257);
        expect_f(0, 0, "R5 before 258");
        tk(1);
        expect_f(0, 1, "R5 terminal 258");
        set_rl(8'd5, 8'd0, 8'd0);
        wr(2'd0, 8'h68); clr();
        tk(4); expect_f(0, 0, "R5 before 5");
        tk(1); expect_f(0, 1, "R5 terminal 5");

        // R6 / R7: mode 71, restart and reload-during-count
        set_rl(8'd9, 8'd5, 8'd0);
        wr(2'd0, 8'h71); clr();
        tk(3); expect_f(0, 0, "R6 waits for start");
        strt(); tk(3); strt(); tk(4);
        expect_f(0, 0, "R6 restart pushes terminal");
        tk(1); expect_f(0, 1, "R6 terminal after restart");
        clr();
        strt(); wr(2'd2, 8'd2); tk(4);
        expect_f(0, 0, "R6 running count unaffected");
        tk(1); expect_f(0, 1, "R6 old value used");
        clr();
        strt(); tk(1); expect_f(0, 0, "R6 new value pending");
        tk(1); expect_f(0, 1, "R6 new value at next start");
        clr(); strt(); tk(12);
        expect_f(0, 1, "R7 short idle in 71");

        // R6: mode 7C joined on every start
        set_rl(8'd3, 8'd1, 8'd0);
        wr(2'd0, 8'h7C); clr();
        tk(5); expect_f(0, 0, "R6 7C waits");
        strt(); tk(258); expect_f(0, 0, "R6 7C before 259");
        tk(1); expect_f(0, 1, "R6 7C terminal 259");
        clr(); wr(2'd1, 8'd0); strt(); tk(255);
        expect_f(0, 0, "R6 7C before 256");
        tk(1); expect_f(0, 1, "R6 7C terminal 256");

        // R8: stop-all, unknown code, long-only stop
        set_rl(8'd2, 8'd3, 8'd0);
        wr(2'd0, 8'h65); strt(); wr(2'd0, 8'h00); clr(); tk(10);
        expect_f(0, 0, "R8 mode 00 stops all");
        wr(2'd0, 8'h65); strt(); wr(2'd0, 8'h42); clr(); tk(10);
        expect_f(0, 0, "R8 unknown code stops all");
        wr(2'd0, 8'h65); strt(); wr(2'd0, 8'h05); clr(); tk(2);
        expect_f(1, 0, "R8 05 keeps short");
        clr(); tk(2);
        expect_f(1, 0, "R8 05 stops long");

        // R9: 85 cut-off on running short counter
        set_rl(8'd3, 8'd0, 8'd0);
        wr(2'd0, 8'h65); strt(); wr(2'd0, 8'h85); clr(); strt();
        tk(9); clr(); tk(2); expect_f(0, 0, "R9 85 before 12");
        tk(1); expect_f(1, 0, "R9 85 12th tick counted");
        clr(); tk(6); expect_f(0, 0, "R9 85 stopped");

        // R9: E5 stops short only
        set_rl(8'd4, 8'd30, 8'd0);
        wr(2'd0, 8'hE5); clr(); tk(3); strt();
        tk(3); expect_f(0, 0, "R9 E5 before first");
        tk(1); expect_f(1, 0, "R9 E5 short runs");
        clr(); tk(4); clr(); tk(4);
        expect_f(1, 0, "R9 E5 12th tick counted");
        clr(); tk(14); expect_f(0, 0, "R9 E5 short cut");
        tk(1); expect_f(0, 1, "R9 E5 long continues");

        // R9: F5 stops both, no re-arm
        set_rl(8'd5, 8'd20, 8'd0);
        wr(2'd0, 8'hF5); clr(); strt();
        tk(5); expect_f(1, 0, "R9 F5 short first");
        clr(); tk(5); clr(); tk(2);
        expect_f(0, 0, "R9 F5 at cut");
        tk(20); expect_f(0, 0, "R9 F5 both stopped");
        strt(); tk(25); expect_f(0, 0, "R9 F5 no re-arm");

        // R9: F1 stops long
        set_rl(8'd0, 8'd6, 8'd0);
        wr(2'd0, 8'hF1); clr(); strt();
        tk(5); strt(); tk(5); expect_f(0, 0, "R9 F1 restarted");
        tk(1); expect_f(0, 1, "R9 F1 terminal tick 11");
        clr(); tk(1); strt(); tk(10);
        expect_f(0, 0, "R9 F1 long not re-armed");

        // R10: sticky, clear, set beats clear
        set_rl(8'd0, 8'd2, 8'd0);
        wr(2'd0, 8'h65); clr(); tk(2); tk(3);
        expect_f(0, 1, "R10 sticky");
        clr(); expect_f(0, 0, "R10 cleared");
        set_rl(8'd0, 8'd1, 8'd0);
        wr(2'd0, 8'h65);
        etu_tick = 1'b1; clr_flags = 1'b1; step(); etu_tick = 1'b0; clr_flags = 1'b0;
        expect_f(0, 1, "R10 set wins over clear");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule